// File: doc/BRIEF.md
# DMA Channel Trigger and Burst Sequencer

This block decides, for a single DMA channel, the cycles in which the channel may start a data transfer. Software arms the channel with a start pulse and a total transfer count. From then on the block sends the datapath a one-cycle issue strobe for each transfer. It waits for the datapath's acknowledge pulse before it issues the next one. It counts the acknowledged transfers down to zero and then pulses a completion flag.

The issue strobe can be gated in three ways. A hardware trigger can gate it, after synchronisation and polarity selection, sensed either on edges or on levels. A peripheral request can gate it, with an enable bit that masks the request for memory-to-memory moves. Trigger permission can be granted one transfer at a time, or in bursts whose length is a power of two set by a 4-bit burst-power code.

In level mode, dropping the trigger does not stop a burst part way through. The channel finishes the burst it has started and only then waits for the trigger to return. In edge mode, a further edge that arrives during a burst is kept in a single pending flag.

Top module: `dma_trig_seq`

## Requirements
- R1: After reset, `issue`, `all_done`, `active` and `cfg_err` are 0 and `remaining` is 0.
- R2: A `sw_start` pulse while idle, with a non-zero `xfer_total` and a burst-power code from 0 to 10, sets `active` and loads `remaining` with `xfer_total` on the next cycle. A `sw_start` while `active` is 1 has no effect on `remaining`.
- R3: At most one transfer is outstanding. After an `issue`, no new `issue` comes before a `xfer_done`. Each `xfer_done` for an outstanding transfer lowers `remaining` by exactly 1 on the next cycle.
- R4: With `cfg_hw_trig_en`=0, transfers are issued without any trigger. With `cfg_preq_en`=1, a transfer is issued only while `periph_req`=1. With `cfg_preq_en`=0, `periph_req` is ignored.
- R5: The trigger passes through a two-flop synchroniser. With `cfg_trig_pol`=1 the active sense is high or rising; with `cfg_trig_pol`=0 it is low or falling. The opposite edge has no effect.
- R6: In edge mode (`cfg_trig_level`=0), each active edge allows 2^`cfg_burst_pow` transfers when `cfg_trig_burst`=1, and one transfer when `cfg_trig_burst`=0.
- R7: An active edge that arrives while edge-mode credit remains is held in a single pending flag, which allows one further burst. Any further edges before that burst starts are lost.
- R8: In level mode (`cfg_trig_level`=1), transfers continue while the trigger is active. When the trigger goes inactive, the current burst is completed and the channel then pauses until the trigger is active again. The count issued at a pause is therefore a multiple of the burst length.
- R9: A `sw_start` with a burst-power code above 10 sets `cfg_err`, leaves the channel idle and issues nothing. The next valid start clears `cfg_err`.
- R10: The acknowledge of the last transfer makes `all_done` high for exactly one cycle and drops `active`, whatever the trigger level. A start with `xfer_total`=0 pulses `all_done` without issuing.
- R11: `issue` is high for exactly one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_raw | input | 1 | Asynchronous hardware trigger |
| periph_req | input | 1 | Peripheral DMA request |
| sw_start | input | 1 | Software start pulse, taken while idle |
| xfer_total | input | 11 | Total transfer count loaded at start |
| xfer_done | input | 1 | Datapath acknowledge, one pulse per transfer |
| cfg_hw_trig_en | input | 1 | 1: transfers wait for trigger credit |
| cfg_trig_pol | input | 1 | 1: active high/rising, 0: active low/falling |
| cfg_trig_level | input | 1 | 0: edge sensing, 1: level sensing |
| cfg_trig_burst | input | 1 | 1: credit is a burst, 0: a single transfer |
| cfg_burst_pow | input | 4 | Burst length is 2^code, codes 0 to 10 valid |
| cfg_preq_en | input | 1 | 1: transfers also need periph_req |
| issue | output | 1 | One-cycle strobe starting a transfer |
| all_done | output | 1 | One-cycle pulse when the count is exhausted |
| active | output | 1 | Channel armed and counting |
| cfg_err | output | 1 | Unsupported burst-power code at the last start |
| remaining | output | 11 | Transfers not yet acknowledged |

## Verification
The case that matters most is a trigger edge that lands in the same cycles as the consumption of burst credit. An edge that arrives while the last issue of a burst spends its credit must be queued or reloaded, neither dropped nor counted twice. The bench provokes this by pulsing the trigger three times into a running eight-transfer burst, and by holding a level trigger through the final acknowledge. A behavioural model, stepped on every clock, judges each cycle's issue, completion, error, active and count. Directed counts then confirm that exactly two bursts ran and that completion won over the still-asserted trigger.

// File: rtl/dts_pkg.sv
// Shared types for the DMA trigger and burst sequencer.
package dts_pkg;
    // How the conditioned trigger grants transfer credit.
    typedef enum logic {
        SENSE_EDGE  = 1'b0,
        SENSE_LEVEL = 1'b1
    } sense_e;
endpackage

// File: rtl/dts_trig_cond.sv
// Trigger conditioner.
// Synchronises the raw trigger, applies the selected polarity and gives the
// active level and a one-cycle active-edge pulse.
// Assumes: polarity is stable while the channel runs; a change may yield one
// spurious edge.
module dts_trig_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_raw,
    input  logic pol_high,
    output logic act_level,
    output logic act_edge
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   act_prev;

    // Synchroniser chain plus one flop of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_raw};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Polarity selection and edge decode.
    always_comb begin
        act_level = pol_high ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];
        act_prev  = pol_high ? last_q : ~last_q;
        act_edge  = act_level & ~act_prev;
    end
endmodule

// File: rtl/dts_burst_credit.sv
// Burst credit keeper.
// Holds the number of transfers the trigger currently allows. In edge mode an
// edge loads one burst and an edge during a burst sets a single pending flag.
// In level mode a new burst is loaded whenever credit is empty and the trigger
// is active, so a released trigger pauses only at a burst boundary.
// Assumes: issue pulses only while credit is non-zero.
module dts_burst_credit
    import dts_pkg::*;
#(
    parameter int BL_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  sense_e          sense,
    input  logic [BL_W-1:0] burst_len,
    input  logic            act_level,
    input  logic            act_edge,
    input  logic            issue,
    output logic            has_credit
);
    logic [BL_W-1:0] left_q;
    logic            pend_q;

    // Credit count and pending-edge flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            pend_q <= 1'b0;
        end else if (!enable) begin
            left_q <= '0;
            pend_q <= 1'b0;
        end else if (left_q != '0) begin
            left_q <= left_q - BL_W'(issue);
            if (sense == SENSE_EDGE) begin
                pend_q <= pend_q | act_edge;
            end
        end else if (sense == SENSE_LEVEL) begin
            pend_q <= 1'b0;
            if (act_level) begin
                left_q <= burst_len;
            end
        end else if (act_edge | pend_q) begin
            left_q <= burst_len;
            pend_q <= pend_q & act_edge;
        end
    end

    // Credit available to the issue logic.
    assign has_credit = (left_q != '0);
endmodule

// File: rtl/dts_xfer_ctrl.sv
// Transfer controller.
// Arms on a software start, checks the burst-power code, issues one transfer
// at a time when allowed, counts acknowledges and flags completion.
// Assumes: xfer_done pulses only for an outstanding transfer.
module dts_xfer_ctrl #(
    parameter int CNT_W   = 11,
    parameter int POW_W   = 4,
    parameter int MAX_POW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_start,
    input  logic [CNT_W-1:0] xfer_total,
    input  logic [POW_W-1:0] burst_pow,
    input  logic             grant,
    input  logic             req_ok,
    input  logic             xfer_done,
    output logic             active,
    output logic             issue,
    output logic             all_done,
    output logic             cfg_err,
    output logic [CNT_W-1:0] remaining
);
    logic             active_q;
    logic             outst_q;
    logic             issue_q;
    logic             done_q;
    logic             err_q;
    logic [CNT_W-1:0] rem_q;
    logic             pow_ok;

    // Supported burst-power codes.
    assign pow_ok = (burst_pow <= POW_W'(MAX_POW));

    // Channel state, outstanding flag, count and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            outst_q  <= 1'b0;
            issue_q  <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            rem_q    <= '0;
        end else begin
            issue_q <= 1'b0;
            done_q  <= 1'b0;
            if (!active_q) begin
                if (sw_start) begin
                    if (!pow_ok) begin
                        err_q <= 1'b1;
                    end else begin
                        err_q <= 1'b0;
                        if (xfer_total == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            active_q <= 1'b1;
                            rem_q    <= xfer_total;
                        end
                    end
                end
            end else if (outst_q) begin
                if (xfer_done) begin
                    outst_q <= 1'b0;
                    rem_q   <= rem_q - CNT_W'(1);
                    if (rem_q == CNT_W'(1)) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end
                end
            end else if (grant && req_ok) begin
                issue_q <= 1'b1;
                outst_q <= 1'b1;
            end
        end
    end

    assign active    = active_q;
    assign issue     = issue_q;
    assign all_done  = done_q;
    assign cfg_err   = err_q;
    assign remaining = rem_q;
endmodule

// File: rtl/dma_trig_seq.sv
// DMA channel trigger and burst sequencer, top level.
// Joins the trigger conditioner, the burst credit keeper and the transfer
// controller, and forms the gating terms from the configuration bits.
// Assumes: configuration is stable while the channel is active.
module dma_trig_seq
    import dts_pkg::*;
#(
    parameter int MAX_POW     = 10,
    parameter int POW_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = MAX_POW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_raw,
    input  logic             periph_req,
    input  logic             sw_start,
    input  logic [CNT_W-1:0] xfer_total,
    input  logic             xfer_done,
    input  logic             cfg_hw_trig_en,
    input  logic             cfg_trig_pol,
    input  logic             cfg_trig_level,
    input  logic             cfg_trig_burst,
    input  logic [POW_W-1:0] cfg_burst_pow,
    input  logic             cfg_preq_en,
    output logic             issue,
    output logic             all_done,
    output logic             active,
    output logic             cfg_err,
    output logic [CNT_W-1:0] remaining
);
    localparam int BL_W = MAX_POW + 1;

    logic            act_level;
    logic            act_edge;
    logic            has_credit;
    logic            grant;
    logic            req_ok;
    logic            credit_en;
    logic [BL_W-1:0] burst_len;

    // Gating terms and burst length from configuration.
    assign burst_len = cfg_trig_burst ? (BL_W'(1) << cfg_burst_pow) : BL_W'(1);
    assign credit_en = active & cfg_hw_trig_en;
    assign grant     = ~cfg_hw_trig_en | has_credit;
    assign req_ok    = ~cfg_preq_en | periph_req;

    dts_trig_cond #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_raw (trig_raw),
        .pol_high (cfg_trig_pol),
        .act_level(act_level),
        .act_edge (act_edge)
    );

    dts_burst_credit #(
        .BL_W(BL_W)
    ) u_credit (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (credit_en),
        .sense     (sense_e'(cfg_trig_level)),
        .burst_len (burst_len),
        .act_level (act_level),
        .act_edge  (act_edge),
        .issue     (issue),
        .has_credit(has_credit)
    );

    dts_xfer_ctrl #(
        .CNT_W  (CNT_W),
        .POW_W  (POW_W),
        .MAX_POW(MAX_POW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_start  (sw_start),
        .xfer_total(xfer_total),
        .burst_pow (cfg_burst_pow),
        .grant     (grant),
        .req_ok    (req_ok),
        .xfer_done (xfer_done),
        .active    (active),
        .issue     (issue),
        .all_done  (all_done),
        .cfg_err   (cfg_err),
        .remaining (remaining)
    );
endmodule

// File: rtl/dts_checker.sv
// Property checker for the sequencer, bound to the top level.
// Tracks its own outstanding-transfer flag from the port traffic.
module dts_checker #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue,
    input logic             all_done,
    input logic             active,
    input logic             cfg_err,
    input logic             xfer_done,
    input logic [CNT_W-1:0] remaining
);
    logic chk_out;

    // Outstanding flag seen from issue and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_out <= 1'b0;
        end else if (issue) begin
            chk_out <= 1'b1;
        end else if (xfer_done) begin
            chk_out <= 1'b0;
        end
    end

    AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue); // R11
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !chk_out); // R3
    AST_ISSUE_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> active); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |=> !all_done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |-> !active); // R10
    AST_ERR_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!active && !issue)); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |->
            (remaining == $past(remaining) || remaining == $past(remaining) - CNT_W'(1))); // R3
    AST_ACK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && xfer_done && chk_out) |=> (remaining == $past(remaining) - CNT_W'(1))); // R3
endmodule

bind dma_trig_seq dts_checker #(
    .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .all_done (all_done),
    .active   (active),
    .cfg_err  (cfg_err),
    .xfer_done(xfer_done),
    .remaining(remaining)
);

// File: tb/dma_trig_seq_tb_top.sv
// Bench for the sequencer: behavioural reference model stepped on every clock
// plus directed scenarios with counts derived from the requirements.
module dma_trig_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 11;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_raw = 1'b0;
    logic             periph_req = 1'b0;
    logic             sw_start = 1'b0;
    logic [CNT_W-1:0] xfer_total = '0;
    logic             xfer_done = 1'b0;
    logic             cfg_hw_trig_en = 1'b0;
    logic             cfg_trig_pol = 1'b0;
    logic             cfg_trig_level = 1'b0;
    logic             cfg_trig_burst = 1'b0;
    logic [3:0]       cfg_burst_pow = 4'd0;
    logic             cfg_preq_en = 1'b0;
    logic             issue;
    logic             all_done;
    logic             active;
    logic             cfg_err;
    logic [CNT_W-1:0] remaining;

    int  tests = 0;
    int  fails = 0;
    int  n_issued = 0;
    int  n_done = 0;
    int  rsp_lat = 1;
    int  rsp_wait = 0;
    bit  tb_over = 1'b0;

    // Reference model state.
    bit  m_s1, m_s2, m_pv, m_act, m_out, m_iss, m_done, m_err, m_pend;
    int  m_rem, m_bl;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_trig_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_raw      (trig_raw),
        .periph_req    (periph_req),
        .sw_start      (sw_start),
        .xfer_total    (xfer_total),
        .xfer_done     (xfer_done),
        .cfg_hw_trig_en(cfg_hw_trig_en),
        .cfg_trig_pol  (cfg_trig_pol),
        .cfg_trig_level(cfg_trig_level),
        .cfg_trig_burst(cfg_trig_burst),
        .cfg_burst_pow (cfg_burst_pow),
        .cfg_preq_en   (cfg_preq_en),
        .issue         (issue),
        .all_done      (all_done),
        .active        (active),
        .cfg_err       (cfg_err),
        .remaining     (remaining)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_ch(input int total);
        @(negedge clk);
        xfer_total = CNT_W'(total);
        sw_start   = 1'b1;
        @(negedge clk);
        sw_start   = 1'b0;
    endtask

    task automatic pulse_trig(input bit level_on);
        @(negedge clk);
        trig_raw = level_on;
        @(negedge clk);
        trig_raw = ~level_on;
    endtask

    task automatic wait_done(input int base);
        for (int i = 0; i < 5000 && n_done == base; i++) @(negedge clk);
    endtask

    // Datapath stand-in: acknowledge each issue after rsp_lat cycles.
    initial begin
        forever begin
            @(negedge clk);
            xfer_done = 1'b0;
            if (rsp_wait == 1) xfer_done = 1'b1;
            if (rsp_wait > 0) rsp_wait--;
            if (issue === 1'b1) rsp_wait = rsp_lat;
        end
    end

    // Event counters sampled at the clock.
    always @(posedge clk) begin
        if (rst_n && issue === 1'b1) n_issued++;
        if (rst_n && all_done === 1'b1) n_done++;
    end

    // Behavioural reference model, one step per clock.
    always @(posedge clk) begin : ref_model
        bit act, actp, edg, grant, reqok;
        bit n_act, n_out, n_iss, n_dn, n_err, n_pend;
        int len, n_rem, n_bl;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_pv = 0; m_act = 0; m_out = 0; m_iss = 0;
            m_done = 0; m_err = 0; m_pend = 0; m_rem = 0; m_bl = 0;
        end else begin
            act   = cfg_trig_pol ? m_s2 : !m_s2;
            actp  = cfg_trig_pol ? m_pv : !m_pv;
            edg   = act && !actp;
            len   = cfg_trig_burst ? (1 << cfg_burst_pow) : 1;
            grant = !cfg_hw_trig_en || (m_bl != 0);
            reqok = !cfg_preq_en || periph_req;
            n_act = m_act; n_out = m_out; n_err = m_err; n_rem = m_rem;
            n_bl = m_bl; n_pend = m_pend; n_iss = 0; n_dn = 0;
            if (!m_act) begin
                if (sw_start) begin
                    if (cfg_burst_pow > 10) n_err = 1;
                    else begin
                        n_err = 0;
                        if (xfer_total == 0) n_dn = 1;
                        else begin n_act = 1; n_rem = int'(xfer_total); end
                    end
                end
            end else if (m_out) begin
                if (xfer_done) begin
                    n_out = 0; n_rem = m_rem - 1;
                    if (m_rem == 1) begin n_act = 0; n_dn = 1; end
                end
            end else if (grant && reqok) begin
                n_iss = 1; n_out = 1;
            end
            if (!(m_act && cfg_hw_trig_en)) begin
                n_bl = 0; n_pend = 0;
            end else if (m_bl != 0) begin
                n_bl = m_bl - (m_iss ? 1 : 0);
                if (!cfg_trig_level) n_pend = m_pend || edg;
            end else if (cfg_trig_level) begin
                n_pend = 0;
                if (act) n_bl = len;
            end else if (edg || m_pend) begin
                n_bl = len; n_pend = m_pend && edg;
            end
            m_pv = m_s2; m_s2 = m_s1; m_s1 = trig_raw;
            m_act = n_act; m_out = n_out; m_iss = n_iss; m_done = n_dn;
            m_err = n_err; m_rem = n_rem; m_bl = n_bl; m_pend = n_pend;
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !tb_over) begin
            chk(issue === m_iss, "R11 issue strobe vs model", int'(issue), int'(m_iss));
            chk(all_done === m_done, "R10 completion pulse vs model", int'(all_done), int'(m_done));
            chk(active === m_act, "R2 active vs model", int'(active), int'(m_act));
            chk(cfg_err === m_err, "R9 error flag vs model", int'(cfg_err), int'(m_err));
            chk(int'(remaining) == m_rem, "R3 remaining vs model", int'(remaining), m_rem);
        end
    end

    // Watchdog.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!tb_over) begin
            tb_over = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Directed scenarios.
    initial begin
        int b, d, paused;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(issue === 1'b0 && all_done === 1'b0, "R1 pulses low after reset", int'(issue), 0);
        chk(active === 1'b0 && cfg_err === 1'b0, "R1 idle after reset", int'(active), 0);
        chk(remaining == '0, "R1 count zero after reset", int'(remaining), 0);

        // R4: free run, peripheral request masked
        cfg_hw_trig_en = 0; cfg_preq_en = 0; periph_req = 0;
        b = n_issued; d = n_done;
        start_ch(5);
        wait_done(d);
        chk(n_issued - b == 5, "R4 free run ignores masked request", n_issued - b, 5);
        chk(n_done - d == 1, "R10 one completion", n_done - d, 1);

        // R4 and R2: request gating, start while active ignored
        cfg_preq_en = 1; periph_req = 0;
        b = n_issued; d = n_done;
        start_ch(3);
        idle(20);
        chk(n_issued == b, "R4 no issue without request", n_issued - b, 0);
        chk(int'(remaining) == 3, "R2 count loaded", int'(remaining), 3);
        start_ch(9);
        idle(5);
        chk(int'(remaining) == 3, "R2 restart while active ignored", int'(remaining), 3);
        periph_req = 1;
        wait_done(d);
        chk(n_issued - b == 3, "R4 request enables transfers", n_issued - b, 3);
        periph_req = 0; cfg_preq_en = 0;

        // R6: edge burst, active high
        cfg_hw_trig_en = 1; cfg_trig_pol = 1; cfg_trig_level = 0;
        cfg_trig_burst = 1; cfg_burst_pow = 4'd2; trig_raw = 0;
        idle(4);
        b = n_issued; d = n_done;
        start_ch(8);
        idle(20);
        chk(n_issued == b, "R6 no trigger no issue", n_issued - b, 0);
        pulse_trig(1'b1);
        idle(60);
        chk(n_issued - b == 4, "R6 one edge one burst of 4", n_issued - b, 4);
        chk(int'(remaining) == 4, "R6 count after burst", int'(remaining), 4);
        pulse_trig(1'b1);
        wait_done(d);
        chk(n_issued - b == 8, "R6 second burst completes", n_issued - b, 8);

        // R5: active low polarity, single transfer per edge
        cfg_trig_pol = 0; cfg_trig_burst = 0; trig_raw = 1;
        idle(4);
        b = n_issued; d = n_done;
        start_ch(3);
        idle(10);
        pulse_trig(1'b0);
        idle(20);
        chk(n_issued - b == 1, "R5 falling edge gives one, rising none", n_issued - b, 1);
        pulse_trig(1'b0);
        idle(20);
        pulse_trig(1'b0);
        wait_done(d);
        chk(n_issued - b == 3, "R6 single mode one per edge", n_issued - b, 3);

        // R7: edges queued during a burst, only one pending
        cfg_trig_pol = 1; cfg_trig_burst = 1; cfg_burst_pow = 4'd3; trig_raw = 0;
        rsp_lat = 2;
        idle(4);
        b = n_issued; d = n_done;
        start_ch(24);
        idle(3);
        pulse_trig(1'b1);
        idle(2);
        pulse_trig(1'b1);
        idle(2);
        pulse_trig(1'b1);
        idle(150);
        chk(n_issued - b == 16, "R7 one pending burst only", n_issued - b, 16);
        chk(int'(remaining) == 8, "R7 count after two bursts", int'(remaining), 8);
        pulse_trig(1'b1);
        wait_done(d);
        chk(n_issued - b == 24, "R7 final burst", n_issued - b, 24);
        rsp_lat = 1;

        // R8: level mode pause on burst boundary and resume
        cfg_trig_level = 1; cfg_burst_pow = 4'd2; trig_raw = 0;
        idle(4);
        b = n_issued; d = n_done;
        start_ch(16);
        @(negedge clk);
        trig_raw = 1;
        for (int i = 0; i < 500 && n_issued - b < 6; i++) @(negedge clk);
        trig_raw = 0;
        idle(60);
        paused = n_issued - b;
        chk(paused % 4 == 0 && paused < 16, "R8 pause on burst boundary", paused, 8);
        idle(30);
        chk(n_issued - b == paused, "R8 stays paused", n_issued - b, paused);
        trig_raw = 1;
        wait_done(d);
        chk(n_issued - b == 16, "R8 resume to completion", n_issued - b, 16);

        // R10: completion while trigger still active
        b = n_issued; d = n_done;
        start_ch(6);
        wait_done(d);
        idle(20);
        chk(active === 1'b0, "R10 idle despite active trigger", int'(active), 0);
        chk(n_issued - b == 6, "R10 exact count with trigger held", n_issued - b, 6);
        trig_raw = 0;

        // R9: unsupported burst-power code
        cfg_hw_trig_en = 0; cfg_trig_level = 0; cfg_burst_pow = 4'd11;
        b = n_issued;
        start_ch(4);
        idle(20);
        chk(cfg_err === 1'b1, "R9 error flag set", int'(cfg_err), 1);
        chk(active === 1'b0 && n_issued == b, "R9 no start on bad code", n_issued - b, 0);
        cfg_burst_pow = 4'd0;
        d = n_done;
        start_ch(2);
        wait_done(d);
        chk(cfg_err === 1'b0, "R9 valid start clears error", int'(cfg_err), 0);

        // R10: zero total completes without issuing
        b = n_issued; d = n_done;
        start_ch(0);
        idle(5);
        chk(n_done - d == 1 && n_issued == b, "R10 zero count completes", n_done - d, 1);

        idle(5);
        tb_over = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule